// File: doc/BRIEF.md
# Chained Control Unit Device Selection

This block decides which control unit on a serially chained I/O channel answers a device selection. The channel offers an 8-bit device address and a select token. The token moves outward through each control unit in cable order, turns around at the far end, and comes back through the same units toward the channel. Each unit owns an aligned window of device addresses and has a priority strap. A unit strapped high compares the address while the token moves outward. A unit strapped low compares it while the token comes back. The far-end unit sees the token only once, so its strap makes no difference.

The token advances one unit per clock. The first unit that compares the address and finds it inside its window keeps the token, and no later position sees it. Within its window a unit has a number of installed devices counted from the bottom of the window. An address above that count is still claimed, but the answer carries a device-not-operational flag. A token that returns to the channel unclaimed yields a no-response answer. The unit count is a parameter. Each unit's window base, window size code, strap and installed device count are static inputs.

Top module: `cu_chain_sel`

## Requirements
- R1: While reset is asserted, and at the first clock edge after it, `busy` and `rsp_valid` are low.
- R2: A `sel_start` sampled high while `busy` is low captures `sel_addr`, and `busy` is high from the next cycle on.
- R3: The token visits unit indices 0, 1, ..., N_CU-1 outbound and then N_CU-2, ..., 0 inbound. The last unit (index N_CU-1) is visited once, at position N_CU, and compares there whatever its strap.
- R4: A unit with index i and `cu_high[i]`=1 compares only at position i+1. With `cu_high[i]`=0 it compares only at position 2*N_CU-1-i.
- R5: Size code s in 0..4 gives a window of 8<<s addresses, and codes 5 to 7 give 128. The window starts at the unit's base rounded down to a multiple of the window size, so low base bits inside the window are ignored.
- R6: When several units would claim an address, the unit with the lowest comparing position wins. No later unit is reported.
- R7: The offset of the address from the window start is compared with the unit's installed count. If the offset is below the count, `rsp_dno`=0. Otherwise the unit still claims the address and `rsp_dno`=1.
- R8: If no unit claims the address, a response arrives at position 2*N_CU-1 with `rsp_none`=1, `rsp_dno`=0 and `rsp_unit`=0.
- R9: `rsp_valid` pulses P cycles after the edge that sampled `sel_start`, where P is the winning position.
- R10: `sel_start` is ignored while `busy` is high. The captured address and the pending answer are unchanged, and no extra response is produced.
- R11: `rsp_valid` lasts one cycle and `busy` is low in that cycle. A start presented in that same cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_start | input | 1 | Launch a selection |
| sel_addr | input | 8 | Device address to select |
| cu_base | input | N_CU*8 | Window base per unit, unit i at bits [8i+7:8i] |
| cu_size | input | N_CU*3 | Window size code per unit, unit i at bits [3i+2:3i] |
| cu_high | input | N_CU | Priority strap per unit, 1 = compare outbound |
| cu_ndev | input | N_CU*8 | Installed device count per unit, unit i at bits [8i+7:8i] |
| busy | output | 1 | Selection in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_unit | output | $clog2(N_CU) | Index of the claiming unit |
| rsp_dno | output | 1 | Claimed address has no installed device |
| rsp_none | output | 1 | No unit claimed the address |

## Verification
The hardest case to reach is a tie between two overlapping windows, where the answer depends on the straps. The bench widens one unit's window over another unit's window and then flips the other unit's strap. The same address must first go to one unit at an early outbound position and then to the other unit. A second hard case is a start issued while a long inbound walk is still running, or in the exact cycle a response strobes. The bench times these stimuli against the expected response cycle, which the scoreboard computes from each unit's position.

// File: rtl/cusel_pkg.sv
package cusel_pkg;

    localparam int ADDR_W = 8;
    localparam int SZ_W   = 3;
    localparam int SZ_MAX = 4;

    // low-bit mask of a window: code s -> (8<<s)-1, codes above SZ_MAX clamp
    function automatic logic [ADDR_W-1:0] win_mask(input logic [SZ_W-1:0] code);
        logic [SZ_W-1:0] c;
        c = (code > SZ_W'(SZ_MAX)) ? SZ_W'(SZ_MAX) : code;
        return (ADDR_W'(8) << c) - ADDR_W'(1);
    endfunction

endpackage

// File: rtl/cu_window.sv
module cu_window
    import cusel_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [SZ_W-1:0]   size_code,
    input  logic [ADDR_W-1:0] ndev,
    output logic              in_win,
    output logic              dev_ok
);
    logic [ADDR_W-1:0] low_m;
    logic [ADDR_W-1:0] offs;

    always_comb begin
        low_m  = win_mask(size_code);
        offs   = addr & low_m;
        in_win = ((addr ^ base) & ~low_m) == '0;
        dev_ok = offs < ndev;
    end
endmodule

// File: rtl/cu_walk.sv
module cu_walk #(
    parameter int N_CU   = 4,
    parameter int POS_W  = $clog2(2*N_CU),
    parameter int UNIT_W = $clog2(N_CU)
) (
    input  logic [POS_W-1:0]  step,
    output logic [UNIT_W-1:0] idx,
    output logic              outward,
    output logic              turn
);
    localparam int LAST = 2*N_CU - 1;

    always_comb begin
        turn = (int'(step) == N_CU);
        if (int'(step) <= N_CU) begin
            outward = 1'b1;
            idx     = UNIT_W'(int'(step) - 1);
        end else begin
            outward = 1'b0;
            idx     = UNIT_W'(LAST - int'(step));
        end
    end
endmodule

// File: rtl/cu_chain_sel.sv
module cu_chain_sel
    import cusel_pkg::*;
#(
    parameter int N_CU   = 4,
    parameter int UNIT_W = $clog2(N_CU)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sel_start,
    input  logic [ADDR_W-1:0]      sel_addr,
    input  logic [N_CU*ADDR_W-1:0] cu_base,
    input  logic [N_CU*SZ_W-1:0]   cu_size,
    input  logic [N_CU-1:0]        cu_high,
    input  logic [N_CU*ADDR_W-1:0] cu_ndev,
    output logic                   busy,
    output logic                   rsp_valid,
    output logic [UNIT_W-1:0]      rsp_unit,
    output logic                   rsp_dno,
    output logic                   rsp_none
);
    localparam int POS_W = $clog2(2*N_CU);
    localparam int LAST  = 2*N_CU - 1;

    typedef struct packed {
        logic              busy;
        logic [POS_W-1:0]  step;
        logic [ADDR_W-1:0] addr;
        logic              valid;
        logic [UNIT_W-1:0] unit;
        logic              dno;
        logic              none;
    } st_t;

    st_t st_d, st_q;

    logic [N_CU-1:0]   in_win;
    logic [N_CU-1:0]   dev_ok;
    logic [UNIT_W-1:0] cur_idx;
    logic              cur_out;
    logic              cur_turn;
    logic              cmp_now;
    logic              claim;

    for (genvar g = 0; g < N_CU; g++) begin : g_unit
        cu_window u_win (
            .addr      (st_q.addr),
            .base      (cu_base[g*ADDR_W +: ADDR_W]),
            .size_code (cu_size[g*SZ_W +: SZ_W]),
            .ndev      (cu_ndev[g*ADDR_W +: ADDR_W]),
            .in_win    (in_win[g]),
            .dev_ok    (dev_ok[g])
        );
    end

    cu_walk #(.N_CU(N_CU), .POS_W(POS_W), .UNIT_W(UNIT_W)) u_walk (
        .step    (st_q.step),
        .idx     (cur_idx),
        .outward (cur_out),
        .turn    (cur_turn)
    );

    always_comb begin
        cmp_now = cur_turn || (cur_out ? cu_high[cur_idx] : !cu_high[cur_idx]);
        claim   = cmp_now && in_win[cur_idx];

        st_d       = st_q;
        st_d.valid = 1'b0;
        if (!st_q.busy) begin
            if (sel_start) begin
                st_d.busy = 1'b1;
                st_d.step = POS_W'(1);
                st_d.addr = sel_addr;
            end
        end else if (claim) begin
            st_d.busy  = 1'b0;
            st_d.valid = 1'b1;
            st_d.unit  = cur_idx;
            st_d.dno   = !dev_ok[cur_idx];
            st_d.none  = 1'b0;
        end else if (int'(st_q.step) == LAST) begin
            st_d.busy  = 1'b0;
            st_d.valid = 1'b1;
            st_d.unit  = '0;
            st_d.dno   = 1'b0;
            st_d.none  = 1'b1;
        end else begin
            st_d.step = st_q.step + POS_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy      = st_q.busy;
    assign rsp_valid = st_q.valid;
    assign rsp_unit  = st_q.unit;
    assign rsp_dno   = st_q.dno;
    assign rsp_none  = st_q.none;

    // R11
    one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R2
    start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && sel_start) |=> busy);

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(st_q.addr));

    // R8
    none_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_none && rsp_dno));

    // R9
    step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (st_q.step != '0 && int'(st_q.step) <= LAST));

endmodule

// File: tb/cu_chain_sel_test.sv
module cu_chain_sel_test;
    localparam int N = 4;
    localparam int UW = 2;

    logic clk = 0;
    logic rst_n = 0;
    logic sel_start = 0;
    logic [7:0] sel_addr = '0;
    logic [N*8-1:0] cu_base;
    logic [N*3-1:0] cu_size;
    logic [N-1:0]   cu_high;
    logic [N*8-1:0] cu_ndev;
    logic busy, rsp_valid, rsp_dno, rsp_none;
    logic [UW-1:0] rsp_unit;

    int cfg_base [N];
    int cfg_size [N];
    bit cfg_high [N];
    int cfg_ndev [N];

    always_comb begin
        for (int u = 0; u < N; u++) begin
            cu_base[u*8 +: 8] = 8'(cfg_base[u]);
            cu_size[u*3 +: 3] = 3'(cfg_size[u]);
            cu_high[u]        = cfg_high[u];
            cu_ndev[u*8 +: 8] = 8'(cfg_ndev[u]);
        end
    end

    cu_chain_sel #(.N_CU(N)) uut (
        .clk(clk), .rst_n(rst_n), .sel_start(sel_start), .sel_addr(sel_addr),
        .cu_base(cu_base), .cu_size(cu_size), .cu_high(cu_high), .cu_ndev(cu_ndev),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_unit(rsp_unit),
        .rsp_dno(rsp_dno), .rsp_none(rsp_none)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0;
    int bad = 0;

    typedef struct {
        int    unit;
        bit    dno;
        bit    none;
        int    at;
        string tag;
    } exp_t;
    exp_t q[$];

    function automatic int pos_of(int u);
        if (u == N-1) return N;
        return cfg_high[u] ? u + 1 : 2*N - 1 - u;
    endfunction

    function automatic exp_t model(int addr, string tag);
        exp_t e;
        int best;
        best = 2*N;
        e.unit = 0; e.dno = 0; e.none = 1; e.tag = tag; e.at = 2*N - 1;
        for (int u = 0; u < N; u++) begin
            int sz, lo;
            sz = (cfg_size[u] > 4) ? 128 : (8 << cfg_size[u]);
            lo = cfg_base[u] - (cfg_base[u] % sz);
            if (addr >= lo && addr < lo + sz && pos_of(u) < best) begin
                best   = pos_of(u);
                e.unit = u;
                e.none = 0;
                e.dno  = (addr - lo) >= cfg_ndev[u];
                e.at   = best;
            end
        end
        return e;
    endfunction

    // call at a falling edge: raises start for the following rising edge
    task automatic launch(int addr, string tag);
        exp_t e;
        e = model(addr, tag);
        e.at = cyc + 1 + e.at;
        q.push_back(e);
        sel_start = 1;
        sel_addr  = 8'(addr);
    endtask

    task automatic wait_idle();
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic go(int addr, string tag);
        @(negedge clk);
        launch(addr, tag);
        @(negedge clk);
        sel_start = 0;
        wait_idle();
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            total++;
            if (q.size() == 0) begin
                bad++;
                $display("FAIL R10: response with nothing pending unit=%0d none=%0b, expected none",
                         rsp_unit, rsp_none);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (int'(rsp_unit) != e.unit || rsp_dno != e.dno ||
                    rsp_none != e.none || cyc != e.at) begin
                    bad++;
                    $display("FAIL %s: unit=%0d dno=%0b none=%0b cyc=%0d expected unit=%0d dno=%0b none=%0b cyc=%0d",
                             e.tag, rsp_unit, rsp_dno, rsp_none, cyc,
                             e.unit, e.dno, e.none, e.at);
                end
            end
        end
    end

    task automatic check(bit ok, string tag, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // unit0 40-4F high, unit1 C0-DF low 6 devices, unit2 80-9F high, unit3 00-07 low
        cfg_base = '{8'h40, 8'hC0, 8'h80, 8'h00};
        cfg_size = '{1, 2, 2, 0};
        cfg_high = '{1, 0, 1, 0};
        cfg_ndev = '{16, 6, 32, 8};

        // R1 reset state
        @(negedge clk);
        check(busy == 0 && rsp_valid == 0, "R1 in reset", busy, 0);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(busy == 0 && rsp_valid == 0, "R1 after reset", busy, 0);

        go(8'h41, "R4 high unit outbound pos1");
        go(8'h4F, "R5 top edge of 16 window");
        go(8'h50, "R8 just above window");
        go(8'hC3, "R4 low unit inbound pos6");
        go(8'hC7, "R7 above installed count");
        go(8'h85, "R9 pos3 latency");
        go(8'h03, "R3 last unit low strap pos4");
        go(8'h20, "R8 unclaimed");

        // flipped straps
        cfg_high = '{0, 1, 1, 1};
        go(8'h41, "R4 unit0 low pos7");
        go(8'hC0, "R4 unit1 high pos2");
        go(8'h07, "R3 last unit high strap pos4");

        // R6 overlap: unit2 widened to 80-FF (code 4)
        cfg_size[2] = 4;
        go(8'hC3, "R6 unit1 pos2 beats unit2 pos3");
        cfg_high[1] = 0;
        go(8'hC3, "R6 unit2 pos3 beats unit1 pos6");
        go(8'hFF, "R5 128 window top");

        // R5 clamp and misaligned base
        cfg_size[2] = 6;
        go(8'h80, "R5 code 6 acts as 128");
        cfg_base[0] = 8'h45; cfg_high[0] = 1;
        go(8'h40, "R5 base low bits ignored");
        cfg_ndev[0] = 0;
        go(8'h40, "R7 zero installed count");

        // R2 / R10: start while busy is ignored
        @(negedge clk);
        launch(8'hC1, "R10 pending answer kept");
        @(negedge clk);
        check(busy == 1, "R2 busy after start", busy, 1);
        sel_addr = 8'h41;
        @(negedge clk);
        sel_start = 0;
        @(negedge clk);
        sel_start = 1; sel_addr = 8'h03;
        @(negedge clk);
        sel_start = 0;
        wait_idle();
        repeat (10) @(negedge clk);
        check(q.size() == 0 && busy == 0, "R10 no extra response", busy, 0);

        // R11 back-to-back: new start in the strobe cycle
        @(negedge clk);
        launch(8'h41, "R11 first");
        @(negedge clk);
        sel_start = 0;
        @(negedge clk);
        check(rsp_valid == 1 && busy == 0, "R11 strobe with busy low", busy, 0);
        launch(8'h85, "R11 accepted in strobe cycle");
        @(negedge clk);
        sel_start = 0;
        check(rsp_valid == 0, "R11 single-cycle strobe", rsp_valid, 0);
        wait_idle();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule